// File: doc/BRIEF.md
# Decoded Left Shifter

This combinational block shifts a 16-bit word left by 0 to 15 positions. Zeros enter at the least significant end, and the bits shifted past the top are lost. The block builds every shifted copy of the input in advance. A select vector with one bit per copy then picks the result. A single mode line sets how that select vector is formed.

In binary mode, a 4-bit amount goes through a binary decoder that drives exactly one select line. In one-hot mode, a 16-bit select vector comes straight from the caller. The selector resolves that vector by priority: the highest set bit wins, and an empty vector gives an all-zero word. The decoder output is also brought out as a port, so the decoded form of the amount can be observed in either mode.

Top module: `shl_decoded_left`

## Requirements
- R1: With `mode_i` = 0 (binary mode), `result_o` equals `data_i` shifted left by the unsigned value of `amount_i`, with zeros filling the vacated low bits and the overflowing high bits discarded.
- R2: `decode_o` has exactly one bit at 1, at the index equal to the value of `amount_i`, in both modes.
- R3: In binary mode, `onehot_i` has no effect on `result_o`.
- R4: With `mode_i` = 1 (one-hot mode) and only bit k of `onehot_i` set, `result_o` equals `data_i` shifted left by k.
- R5: In one-hot mode with several bits of `onehot_i` set, the shift of the highest-indexed set bit is applied.
- R6: In one-hot mode with `onehot_i` all zero, `result_o` is all zero.
- R7: In one-hot mode, `amount_i` has no effect on `result_o`.
- R8: A shift of 0 passes `data_i` through unchanged. A shift of 15 moves `data_i` bit 0 to `result_o` bit 15 and clears every other bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 16 | Word to be shifted |
| amount_i | input | 4 | Binary shift amount, used when mode_i is 0 |
| onehot_i | input | 16 | Direct select vector, bit k meaning shift by k, used when mode_i is 1 |
| mode_i | input | 1 | 0 selects binary amount, 1 selects direct select vector |
| result_o | output | 16 | Shifted word |
| decode_o | output | 16 | One-hot decode of amount_i |

## Verification
The assertions take every input as a known 0 or 1 level. They stay silent while any input still carries X or Z, so they say nothing before the bench first drives the ports. The bench drives all four inputs to defined values from the first cycle on and changes them only between sampling points. The one-hot properties expect that `onehot_i` may hold any pattern, including zero and several bits set. The stimulus covers those cases on purpose: single bits, random multi-bit vectors and the empty vector.

// File: rtl/shl_pkg.sv
package shl_pkg;

    parameter int unsigned WORD_W = 16;
    parameter int unsigned AMT_W  = $clog2(WORD_W);

    typedef enum logic {
        SEL_BINARY = 1'b0,
        SEL_DIRECT = 1'b1
    } sel_mode_e;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [AMT_W-1:0]  amt_t;

endpackage

// File: rtl/shl_bin_decoder.sv
module shl_bin_decoder #(
    parameter int unsigned IN_W  = 4,
    localparam int unsigned OUT_W = 1 << IN_W
) (
    input  logic [IN_W-1:0]  code_i,
    output logic [OUT_W-1:0] hot_o
);
    // stage k holds a vector of 2**k live bits; the upper bits stay zero
    logic [OUT_W-1:0] stage [0:IN_W];

    assign stage[0] = OUT_W'(1);

    for (genvar k = 0; k < IN_W; k++) begin : g_stage
        localparam int unsigned HALF = 1 << k;
        for (genvar i = 0; i < OUT_W; i++) begin : g_bit
            if (i < HALF) begin : g_lo
                assign stage[k+1][i] = stage[k][i] & ~code_i[k];
            end else if (i < 2 * HALF) begin : g_hi
                assign stage[k+1][i] = stage[k][i-HALF] & code_i[k];
            end else begin : g_unused
                assign stage[k+1][i] = 1'b0;
            end
        end
    end

    assign hot_o = stage[IN_W];
endmodule

// File: rtl/shl_copy_bank.sv
module shl_copy_bank #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] word_i,
    output logic [W-1:0] copy_o [0:W-1]
);
    for (genvar k = 0; k < W; k++) begin : g_copy
        if (k == 0) begin : g_zero
            assign copy_o[k] = word_i;
        end else begin : g_shift
            assign copy_o[k] = {word_i[W-1-k:0], {k{1'b0}}};
        end
    end
endmodule

// File: rtl/shl_prio_select.sv
module shl_prio_select #(
    parameter int unsigned W = 16,
    parameter int unsigned N = 16
) (
    input  logic [W-1:0] cand_i [0:N-1],
    input  logic [N-1:0] pick_i,
    output logic [W-1:0] out_o
);
    // later links override earlier ones, so the highest set pick wins
    logic [W-1:0] link [0:N];

    assign link[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_link
        assign link[i+1] = pick_i[i] ? cand_i[i] : link[i];
    end

    assign out_o = link[N];
endmodule

// File: rtl/shl_decoded_left.sv
module shl_decoded_left
    import shl_pkg::*;
#(
    parameter int unsigned W = shl_pkg::WORD_W,
    localparam int unsigned A = $clog2(W)
) (
    input  logic [W-1:0] data_i,
    input  logic [A-1:0] amount_i,
    input  logic [W-1:0] onehot_i,
    input  logic         mode_i,
    output logic [W-1:0] result_o,
    output logic [W-1:0] decode_o
);
    sel_mode_e    mode;
    logic [W-1:0] pick;
    logic [W-1:0] copies [0:W-1];

    assign mode = sel_mode_e'(mode_i);

    shl_bin_decoder #(.IN_W(A)) u_dec (
        .code_i (amount_i),
        .hot_o  (decode_o)
    );

    always_comb begin
        unique case (mode)
            SEL_BINARY: pick = decode_o;
            SEL_DIRECT: pick = onehot_i;
            default:    pick = '0;
        endcase
    end

    shl_copy_bank #(.W(W)) u_bank (
        .word_i (data_i),
        .copy_o (copies)
    );

    shl_prio_select #(.W(W), .N(W)) u_sel (
        .cand_i (copies),
        .pick_i (pick),
        .out_o  (result_o)
    );
endmodule

// File: rtl/shl_decoded_left_chk.sv
module shl_decoded_left_chk #(
    parameter int unsigned W = 16,
    localparam int unsigned A = $clog2(W)
) (
    input logic [W-1:0] data_i,
    input logic [A-1:0] amount_i,
    input logic [W-1:0] onehot_i,
    input logic         mode_i,
    input logic [W-1:0] result_o,
    input logic [W-1:0] decode_o
);
    logic         known;
    logic [W-1:0] low_mask;
    logic [W-1:0] top_shift;
    int           top_idx;

    assign known    = !$isunknown({data_i, amount_i, onehot_i, mode_i});
    assign low_mask = (W'(1) << amount_i) - W'(1);

    always_comb begin
        top_idx = -1;
        for (int k = 0; k < W; k++) begin
            if (onehot_i[k]) top_idx = k;
        end
        top_shift = (top_idx < 0) ? '0 : (data_i << top_idx);
    end

    always_comb begin
        if (known) begin
            a_r2_decode_single: assert ($onehot(decode_o));
            a_r2_decode_index:  assert (decode_o[amount_i]);
            if (!mode_i) begin
                a_r1_low_zero: assert ((result_o & low_mask) == '0);
                a_r1_shift:    assert (result_o == W'(data_i << amount_i));
            end else begin
                a_r6_empty_zero: assert (onehot_i != '0 || result_o == '0);
                a_r5_highest:    assert (result_o == top_shift);
            end
        end
    end
endmodule

bind shl_decoded_left shl_decoded_left_chk #(.W(W)) u_chk (
    .data_i   (data_i),
    .amount_i (amount_i),
    .onehot_i (onehot_i),
    .mode_i   (mode_i),
    .result_o (result_o),
    .decode_o (decode_o)
);

// File: tb/shl_decoded_left_tb.sv
module shl_decoded_left_tb;
    localparam int W = 16;
    localparam int A = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] data_i   = '0;
    logic [A-1:0] amount_i = '0;
    logic [W-1:0] onehot_i = '0;
    logic         mode_i   = 1'b0;
    logic [W-1:0] result_o;
    logic [W-1:0] decode_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    shl_decoded_left u_dut (
        .data_i   (data_i),
        .amount_i (amount_i),
        .onehot_i (onehot_i),
        .mode_i   (mode_i),
        .result_o (result_o),
        .decode_o (decode_o)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] d,
                                           input logic [A-1:0] amt,
                                           input logic [W-1:0] sel,
                                           input logic m);
        logic [W-1:0] r;
        r = '0;
        if (!m) begin
            r = d;
            for (int s = 0; s < int'(amt); s++) r = {r[W-2:0], 1'b0};
            return r;
        end
        for (int k = W - 1; k >= 0; k--) begin
            if (sel[k]) begin
                r = d;
                for (int s = 0; s < k; s++) r = {r[W-2:0], 1'b0};
                return r;
            end
        end
        return '0;
    endfunction

    task automatic check(input string req, input logic [W-1:0] got,
                         input logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] d, input logic [A-1:0] a,
                         input logic [W-1:0] s, input logic m);
        @(posedge clk);
        data_i   = d;
        amount_i = a;
        onehot_i = s;
        mode_i   = m;
        @(negedge clk);
    endtask

    task automatic run_cmp(input string req);
        check(req, result_o, model(data_i, amount_i, onehot_i, mode_i));
    endtask

    initial begin
        logic [W-1:0] keep;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: all inputs zero
        check("R8 reset result", result_o, '0);
        check("R2 reset decode", decode_o, 16'h0001);

        // R1 / R2: every binary amount with several random words
        for (int a = 0; a < W; a++) begin
            for (int r = 0; r < 4; r++) begin
                logic [W-1:0] d;
                d = W'($urandom);
                drive(d, A'(a), W'($urandom), 1'b0);
                check("R1 binary shift", result_o, W'(d << a));
                check("R2 decode", decode_o, W'(1) << a);
            end
        end

        // R8 boundaries
        drive(16'hA5C3, 4'd0, '0, 1'b0);
        check("R8 zero shift", result_o, 16'hA5C3);
        drive(16'h7FFF, 4'd15, '0, 1'b0);
        check("R8 max shift", result_o, 16'h8000);
        drive(16'hFFFE, 4'd15, '0, 1'b0);
        check("R8 max shift low bit clear", result_o, 16'h0000);

        // R3: direct vector ignored in binary mode
        drive(16'h1234, 4'd3, 16'h0000, 1'b0);
        keep = result_o;
        drive(16'h1234, 4'd3, 16'hFFFF, 1'b0);
        check("R3 onehot ignored", result_o, keep);
        drive(16'h1234, 4'd3, 16'h8001, 1'b0);
        check("R3 onehot ignored", result_o, keep);

        // R4: single select bits
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] d;
            d = W'($urandom);
            drive(d, A'($urandom), W'(1) << k, 1'b1);
            check("R4 single select", result_o, W'(d << k));
        end

        // R6: empty vector
        drive(16'hFFFF, 4'd5, '0, 1'b1);
        check("R6 empty select", result_o, '0);

        // R5: fixed multi-bit cases then random vectors
        drive(16'h0001, 4'd0, 16'h0005, 1'b1);
        check("R5 highest wins", result_o, 16'h0004);
        drive(16'h00FF, 4'd0, 16'hC000, 1'b1);
        check("R5 highest wins", result_o, 16'h8000);
        for (int r = 0; r < 40; r++) begin
            drive(W'($urandom), A'($urandom), W'($urandom), 1'b1);
            run_cmp("R5 random select");
        end

        // R7: amount ignored in one-hot mode, decode still follows it
        drive(16'h0F0F, 4'd0, 16'h0010, 1'b1);
        keep = result_o;
        for (int a = 1; a < W; a += 5) begin
            drive(16'h0F0F, A'(a), 16'h0010, 1'b1);
            check("R7 amount ignored", result_o, keep);
            check("R2 decode in direct mode", decode_o, W'(1) << a);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule